// File: doc/BRIEF.md
# Split Double-Word Operand Transfer Sequencer

This block carries one 64-bit operand between a requesting unit and a 32-bit memory port, as two consecutive word transfers. The operand's location is given by a 6-bit effective-address field that selects an addressing mode and one of eight internal 32-bit address registers. A 16-bit displacement input serves the displacement mode. Some modes change the selected address register as a side effect, the way a stack push or pop would.

A transfer begins on a one-cycle start strobe. The block latches the mode, the register, the direction and the write data, then runs the two memory words under a request/ready handshake. It pulses a done flag when the second word has finished. If the mode and direction do not form a legal combination, the block pulses an error flag and issues no bus cycle. Address registers come out of reset at evenly spaced values set by parameters. From then on, they change only through the side effects of the post-increment and pre-decrement modes.

Top module: `dws_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done_o`, `err_o` and `mem_req_o` are 0 and `rdata_o` is all zeros.
- R2: `ea_i[5:3]` is the mode and `ea_i[2:0]` selects the address register. After reset, register i holds `AR_RESET_BASE + i*AR_RESET_STEP` (defaults 0x1000 and 0x100).
- R3: The first word uses the base address and carries operand bits 63:32. The second word uses base+4 and carries bits 31:0. `mem_we_o` is 1 for a write. A read returns `{first word, second word}` on `rdata_o`.
- R4: Mode 2 (indirect) uses the register value as the base, for reads (`wr_i`=0) and writes (`wr_i`=1), and leaves the register unchanged.
- R5: Mode 3 is legal only for reads. It uses the register value as the base and, once the transfer completes, the register has grown by 8.
- R6: Mode 4 is legal only for writes. The register is reduced by 8, and that reduced value is the base.
- R7: Mode 5 uses the register plus the sign-extended `disp_i` as the base, in either direction, and leaves the register unchanged.
- R8: Modes 0, 1, 6 and 7, a write in mode 3 and a read in mode 4 raise `err_o` for exactly the one cycle after the start. No memory request occurs, and `done_o` stays 0.
- R9: Each word holds `mem_req_o`, the address, the direction and the write word stable until a cycle with `mem_ready_i`=1.
- R10: `done_o` is high for exactly the one cycle after the clock edge at which the second word completes. `mem_req_o` is low in that cycle.
- R11: A start strobe that arrives while a transfer is in progress is ignored. No further request follows the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| ea_i | input | 6 | Mode in bits 5:3, register index in bits 2:0 |
| disp_i | input | 16 | Signed displacement for mode 5 |
| wr_i | input | 1 | 1 = write operand to memory, 0 = read |
| wdata_i | input | 64 | Operand to write |
| rdata_o | output | 64 | Operand read from memory |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Illegal mode/direction pulse |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_rdata_i | input | 32 | Memory read word |
| mem_ready_i | input | 1 | Memory completes the current word |

## Verification
Directed sequences cover several cases. Back-to-back mode 3 reads and mode 4 writes on one register show whether the ±8 side effect is applied, whether it is applied before or after the address is used, and whether it is applied only once. An indirect access that follows each of these exposes the committed register value at the address port. Displacements of 0x7FFF and 0x8000 separate sign extension from zero extension, and each illegal combination is tried on its own. A seeded random mix of modes, registers, directions, displacements and ready wait states of 0 to 3 cycles then tests word ordering, hold-while-waiting and done timing against a bench model of the register file. A start strobe injected mid-transfer checks that a busy start is ignored.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } seq_state_e;

    localparam logic [2:0] MODE_IND  = 3'd2;
    localparam logic [2:0] MODE_POST = 3'd3;
    localparam logic [2:0] MODE_PRE  = 3'd4;
    localparam logic [2:0] MODE_DISP = 3'd5;

endpackage

// File: rtl/dws_addr_gen.sv
module dws_addr_gen
    import dws_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DISPW    = 16,
    parameter int OP_BYTES = 8
) (
    input  logic [2:0]       mode_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    areg_i,
    input  logic [DISPW-1:0] disp_i,
    output logic             legal_o,
    output logic [AW-1:0]    base_o,
    output logic [AW-1:0]    next_o,
    output logic             upd_o
);
    localparam logic [AW-1:0] STEP = AW'(OP_BYTES);

    logic [AW-1:0] disp_ext;
    assign disp_ext = {{(AW-DISPW){disp_i[DISPW-1]}}, disp_i};

    always_comb begin
        legal_o = 1'b0;
        base_o  = areg_i;
        next_o  = areg_i;
        upd_o   = 1'b0;
        case (mode_i)
            MODE_IND: begin
                legal_o = 1'b1;
            end
            MODE_POST: begin
                legal_o = !wr_i;
                next_o  = areg_i + STEP;
                upd_o   = 1'b1;
            end
            MODE_PRE: begin
                legal_o = wr_i;
                base_o  = areg_i - STEP;
                next_o  = areg_i - STEP;
                upd_o   = 1'b1;
            end
            MODE_DISP: begin
                legal_o = 1'b1;
                base_o  = areg_i + disp_ext;
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dws_areg_file.sv
module dws_areg_file #(
    parameter int            AW            = 32,
    parameter int            REGW          = 3,
    parameter logic [AW-1:0] AR_RESET_BASE = 32'h0000_1000,
    parameter logic [AW-1:0] AR_RESET_STEP = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [REGW-1:0] ridx_i,
    output logic [AW-1:0]   rdata_o,
    input  logic            wen_i,
    input  logic [REGW-1:0] widx_i,
    input  logic [AW-1:0]   wdata_i
);
    localparam int NREG = 2 ** REGW;

    logic [AW-1:0] regs_q [NREG];
    logic [AW-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wen_i) begin
            regs_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= AR_RESET_BASE + AW'(i) * AR_RESET_STEP;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q[ridx_i];

    // R5 / R6: a committed update lands in the selected register
    p_commit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wen_i |=> regs_q[$past(widx_i)] == $past(wdata_i));

endmodule

// File: rtl/dws_seq.sv
module dws_seq
    import dws_pkg::*;
#(
    parameter int            AW            = 32,
    parameter int            DW            = 32,
    parameter int            DISPW         = 16,
    parameter int            REGW          = 3,
    parameter logic [AW-1:0] AR_RESET_BASE = 32'h0000_1000,
    parameter logic [AW-1:0] AR_RESET_STEP = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REGW+2:0]   ea_i,
    input  logic [DISPW-1:0]  disp_i,
    input  logic              wr_i,
    input  logic [2*DW-1:0]   wdata_i,
    output logic [2*DW-1:0]   rdata_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic              mem_ready_i
);
    localparam int            WORD_BYTES = DW / 8;
    localparam int            OP_BYTES   = 2 * WORD_BYTES;
    localparam logic [AW-1:0] WORD_OFS   = AW'(WORD_BYTES);

    typedef struct packed {
        seq_state_e       st;
        logic             wr;
        logic [AW-1:0]    base;
        logic [AW-1:0]    nval;
        logic             upd;
        logic [REGW-1:0]  idx;
        logic [2*DW-1:0]  wdata;
        logic [2*DW-1:0]  rdata;
        logic             done;
        logic             err;
    } seq_t;

    seq_t s_q, s_d;

    logic [2:0]      mode;
    logic [REGW-1:0] ridx;
    logic [AW-1:0]   areg;
    logic            legal;
    logic [AW-1:0]   base;
    logic [AW-1:0]   nval;
    logic            upd;
    logic            rf_wen;

    assign mode = ea_i[REGW+2:REGW];
    assign ridx = ea_i[REGW-1:0];

    dws_areg_file #(
        .AW            (AW),
        .REGW          (REGW),
        .AR_RESET_BASE (AR_RESET_BASE),
        .AR_RESET_STEP (AR_RESET_STEP)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ridx_i  (ridx),
        .rdata_o (areg),
        .wen_i   (rf_wen),
        .widx_i  (s_q.idx),
        .wdata_i (s_q.nval)
    );

    dws_addr_gen #(
        .AW       (AW),
        .DISPW    (DISPW),
        .OP_BYTES (OP_BYTES)
    ) u_agen (
        .mode_i  (mode),
        .wr_i    (wr_i),
        .areg_i  (areg),
        .disp_i  (disp_i),
        .legal_o (legal),
        .base_o  (base),
        .next_o  (nval),
        .upd_o   (upd)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        rf_wen   = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (legal) begin
                        s_d.st    = ST_HI;
                        s_d.wr    = wr_i;
                        s_d.base  = base;
                        s_d.nval  = nval;
                        s_d.upd   = upd;
                        s_d.idx   = ridx;
                        s_d.wdata = wdata_i;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (mem_ready_i) begin
                    if (!s_q.wr) begin
                        s_d.rdata[2*DW-1:DW] = mem_rdata_i;
                    end
                    s_d.st = ST_LO;
                end
            end
            ST_LO: begin
                if (mem_ready_i) begin
                    if (!s_q.wr) begin
                        s_d.rdata[DW-1:0] = mem_rdata_i;
                    end
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    rf_wen   = s_q.upd;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_o   = (s_q.st != ST_IDLE);
    assign mem_we_o    = mem_req_o && s_q.wr;
    assign mem_addr_o  = (s_q.st == ST_LO) ? s_q.base + WORD_OFS : s_q.base;
    assign mem_wdata_o = (s_q.st == ST_LO) ? s_q.wdata[DW-1:0] : s_q.wdata[2*DW-1:DW];
    assign rdata_o     = s_q.rdata;
    assign done_o      = s_q.done;
    assign err_o       = s_q.err;

    // R8: an illegal request never reaches the bus
    p_err_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o);

    // R8: error and completion never coincide
    p_err_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && done_o));

    // R9: a waiting word holds its request and payload
    p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3: the second word sits one word above the first
    p_second_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o && mem_ready_i))
            |-> mem_addr_o == $past(mem_addr_o) + WORD_OFS);

    // R10: done follows a completed word and the bus is then idle
    p_done_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mem_req_o && $past(mem_req_o && mem_ready_i)));

endmodule

// File: tb/dws_seq_tb.sv
`timescale 1ns/1ps
module dws_seq_tb;

    localparam logic [31:0] BASE0 = 32'h0000_1000;
    localparam logic [31:0] STEP0 = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  ea_i = '0;
    logic [15:0] disp_i = '0;
    logic        wr_i = 1'b0;
    logic [63:0] wdata_i = '0;
    logic [63:0] rdata_o;
    logic        done_o, err_o, mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_ready_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] ar [8];

    always #2.5 clk = ~clk;

    dws_seq u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .ea_i (ea_i),
        .disp_i (disp_i), .wr_i (wr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
        .done_o (done_o), .err_o (err_o), .mem_req_o (mem_req_o),
        .mem_we_o (mem_we_o), .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i), .mem_ready_i (mem_ready_i)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] mode, input logic wr, input logic [31:0] a,
                         input logic [15:0] d, output bit legal, output logic [31:0] base,
                         output logic [31:0] nval, output bit upd);
        legal = 1'b0; base = a; nval = a; upd = 1'b0;
        case (mode)
            3'd2: legal = 1'b1;
            3'd3: begin legal = !wr; nval = a + 32'd8; upd = 1'b1; end
            3'd4: begin legal = wr; base = a - 32'd8; nval = base; upd = 1'b1; end
            3'd5: begin legal = 1'b1; base = a + {{16{d[15]}}, d}; end
            default: legal = 1'b0;
        endcase
    endtask

    task automatic run_op(input logic [2:0] mode, input logic [2:0] r, input logic [15:0] d,
                          input logic wr, input logic [63:0] wd, input int w0, input int w1,
                          input bit poke);
        bit legal, upd;
        logic [31:0] base, nval, a;
        int w;
        model(mode, wr, ar[r], d, legal, base, nval, upd);
        @(negedge clk);
        ea_i = {mode, r}; disp_i = d; wr_i = wr; wdata_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ea_i = 6'($urandom); disp_i = 16'($urandom); wr_i = 1'($urandom); wdata_i = {$urandom, $urandom};
        if (!legal) begin
            chk("R8 error pulse", 64'(err_o), 64'd1);
            chk("R8 no request", 64'(mem_req_o), 64'd0);
            @(negedge clk);
            chk("R8 error one cycle", 64'(err_o), 64'd0);
            chk("R8 still no request", 64'(mem_req_o), 64'd0);
            chk("R8 no done", 64'(done_o), 64'd0);
            return;
        end
        for (int k = 0; k < 2; k++) begin
            a = base + 32'(4 * k);
            w = (k == 0) ? w0 : w1;
            chk($sformatf("R3 word%0d address mode%0d", k, mode), 64'(mem_addr_o), 64'(a));
            chk("R3 direction", 64'(mem_we_o), 64'(wr));
            if (wr) chk($sformatf("R3 write word%0d", k), 64'(mem_wdata_o),
                        (k == 0) ? 64'(wd[63:32]) : 64'(wd[31:0]));
            for (int i = 0; i < w; i++) begin
                mem_ready_i = 1'b0;
                if (poke && k == 0 && i == 0) begin
                    ea_i = {3'd2, 3'd7}; wr_i = 1'b0; start_i = 1'b1;
                end
                @(negedge clk);
                start_i = 1'b0;
                chk("R9 request held", 64'(mem_req_o), 64'd1);
                chk("R9 address held", 64'(mem_addr_o), 64'(a));
                chk("R10 no early done", 64'(done_o), 64'd0);
            end
            mem_ready_i = 1'b1;
            mem_rdata_i = mem_word(a);
            @(negedge clk);
            mem_ready_i = 1'b0;
            mem_rdata_i = '0;
        end
        chk("R10 done pulse", 64'(done_o), 64'd1);
        chk("R10 bus idle at done", 64'(mem_req_o), 64'd0);
        if (!wr) chk("R3 read data order", rdata_o, {mem_word(base), mem_word(base + 32'd4)});
        if (upd) ar[r] = nval;
        @(negedge clk);
        chk("R10 done one cycle", 64'(done_o), 64'd0);
        if (poke) chk("R11 busy start ignored", 64'(mem_req_o), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7391));
        for (int i = 0; i < 8; i++) ar[i] = BASE0 + 32'(i) * STEP0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", 64'(done_o), 64'd0);
        chk("R1 reset err", 64'(err_o), 64'd0);
        chk("R1 reset request", 64'(mem_req_o), 64'd0);
        chk("R1 reset rdata", rdata_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'(mem_req_o), 64'd0);

        // R2: register reset values seen through indirect reads
        for (int r = 0; r < 8; r++) run_op(3'd2, 3'(r), 16'h0, 1'b0, 64'h0, r % 3, 0, 1'b0);
        // R4: indirect write then read, register unchanged
        run_op(3'd2, 3'd1, 16'h0, 1'b1, 64'h1122_3344_5566_7788, 1, 2, 1'b0);
        run_op(3'd2, 3'd1, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // R5: two post-increment reads then an indirect read
        run_op(3'd3, 3'd2, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd3, 3'd2, 16'h0, 1'b0, 64'h0, 2, 1, 1'b0);
        run_op(3'd2, 3'd2, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // R6: two pre-decrement writes then an indirect read
        run_op(3'd4, 3'd3, 16'h0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 1'b0);
        run_op(3'd4, 3'd3, 16'h0, 1'b1, 64'h0123_4567_89AB_CDEF, 3, 0, 1'b0);
        run_op(3'd2, 3'd3, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // R7: displacement extremes, register unchanged
        run_op(3'd5, 3'd4, 16'h7FFF, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd5, 3'd4, 16'h8000, 1'b1, 64'hA5A5_A5A5_5A5A_5A5A, 1, 1, 1'b0);
        run_op(3'd5, 3'd4, 16'hFFF8, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd2, 3'd4, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // R8: every illegal combination
        run_op(3'd0, 3'd0, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd1, 3'd5, 16'h0, 1'b1, 64'h0, 0, 0, 1'b0);
        run_op(3'd6, 3'd6, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd7, 3'd7, 16'h0, 1'b1, 64'h0, 0, 0, 1'b0);
        run_op(3'd3, 3'd0, 16'h0, 1'b1, 64'h0, 0, 0, 1'b0);
        run_op(3'd4, 3'd0, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        run_op(3'd2, 3'd0, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // R11: start during a transfer is ignored
        run_op(3'd3, 3'd5, 16'h0, 1'b0, 64'h0, 2, 1, 1'b1);
        run_op(3'd2, 3'd5, 16'h0, 1'b0, 64'h0, 0, 0, 1'b0);
        // random mix
        for (int n = 0; n < 400; n++) begin
            run_op(3'($urandom), 3'($urandom), 16'($urandom), 1'($urandom),
                   {$urandom, $urandom}, int'($urandom % 4), int'($urandom % 4),
                   ($urandom % 8) == 0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule